// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block decides, one clock cycle at a time, when the primary switch of a flyback converter turns on and off. Its inputs are digitised comparator outputs: a current-sense trip, a second and higher short-winding trip, a demagnetization flag that is high while the secondary stroke is still running, a drain-valley detect, a tick from the frequency oscillator, and a cycle-skip request. Its output is a single gate command and two sticky fault flags.

A stroke begins only when three conditions hold together. The switching period must have elapsed. The transformer must be fully demagnetized. The drain must be at a valley. The sequencer does not follow a free-running clock. After switch-on, the sense inputs are ignored for a leading-edge blanking window, and that window also sets the minimum on-time. An on-time that runs to its ceiling without a trip counts as a fault. After switch-off, the demagnetization flag is ignored for a ringing-suppression window. A fixed-period timer caps how long the sequencer waits for an oscillator tick, so the switching frequency cannot fall below a floor. A valley timeout keeps the sequencer from stalling when no valley appears. Every window is counted in system clock cycles and set by a parameter.

Top module: `qr_cycle_seq`

## Requirements
- R1: A rising edge of gate_on comes at least MIN_PERIOD_CYC cycles after the previous rising edge. It also needs an osc_tick pulse after that previous rising edge, except when MAX_PERIOD_CYC cycles have passed since it; in that case the period counts as elapsed without a tick.
- R2: gate_on never rises in the cycle after one in which demag_active was high. Once demag_active is seen low and every other condition holds, gate_on rises two cycles later.
- R3: For the first BLANK_CYC cycles of every on-time, gate_on stays high whatever cs_trip and sw_trip do. With cs_trip held high, the on-time is exactly BLANK_CYC cycles and no fault is raised.
- R4: If no trip ends the on-time, gate_on falls after exactly MAXON_CYC cycles, fault_maxon becomes 1 and switching stops.
- R5: After a normal switch-off, demag_active is not looked at for RING_CYC cycles. A low level during that window does not count as the end of demagnetization.
- R6: When all other conditions are met, gate_on rises one cycle after valley_det is seen high. If no valley is seen within VALLEY_TO_CYC cycles of the end of demagnetization, the switch turns on anyway. A value of 0 disables this timeout.
- R7: Each cycle has one switch-on only. After a normal switch-off, gate_on stays low for at least RING_CYC+2 cycles, even when cs_trip returns low.
- R8: While skip_req is high, gate_on does not rise. After skip_req clears, gate_on rises one cycle later if the other conditions hold.
- R9: sw_trip seen after blanking ends the on-time and sets fault_short. When sw_trip and cs_trip arrive in the same cycle, sw_trip wins.
- R10: Both fault flags hold their value and gate_on stays low until rst_n is asserted. Reset clears both flags.
- R11: Out of reset, gate_on, fault_maxon and fault_short are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| osc_tick | input | 1 | oscillator period-elapsed pulse |
| demag_active | input | 1 | 1 while the secondary stroke is still running |
| valley_det | input | 1 | drain valley seen |
| cs_trip | input | 1 | current-sense peak reached |
| sw_trip | input | 1 | short-winding threshold exceeded |
| skip_req | input | 1 | cycle-skip request, inhibits switch-on |
| gate_on | output | 1 | gate command for the primary switch |
| fault_maxon | output | 1 | sticky: on-time reached its ceiling |
| fault_short | output | 1 | sticky: short-winding trip |

## Verification
The assertions check on every cycle that no switch-on happens during demagnetization, during a skip request, or before the period gate opens. They also check that blanking holds the gate high, that a switch-off is never followed directly by another switch-on, and that a fault freezes the flags and the gate. The exact lengths of on- and off-times can only be shown by the bench scenarios. These cover the minimum period, the frequency-floor timer without a tick, the valley timeout, a demagnetization end that is delayed or falsely low during ringing, and the release of a skip request. The on-time ceiling, the short-winding priority and the clearing of faults by reset are also shown only by bench scenarios.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

   typedef enum logic [2:0] {
      ST_ON     = 3'd0,
      ST_RING   = 3'd1,
      ST_DEMAG  = 3'd2,
      ST_VALLEY = 3'd3,
      ST_FAULT  = 3'd4
   } qr_state_t;

   function automatic int unsigned qr_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/qr_phase_timer.sv
module qr_phase_timer #(
   parameter int unsigned W     = 8,
   parameter int unsigned LIMIT = 255
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   initial begin : g_chk
      assert (LIMIT < (2 ** W)) else $error("phase timer limit does not fit width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/qr_period_gate.sv
module qr_period_gate #(
   parameter int unsigned MIN_PERIOD_CYC = 1000,
   parameter int unsigned MAX_PERIOD_CYC = 5000,
   parameter int unsigned W              = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic osc_tick,
   output logic period_ok
);
   localparam logic [W-1:0] FLOOR_V = W'(MIN_PERIOD_CYC - 1);
   localparam logic [W-1:0] CAP_V   = W'(MAX_PERIOD_CYC - 1);

   logic [W-1:0] per_cnt;
   logic         tick_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_cnt   <= CAP_V;
         tick_seen <= 1'b0;
      end else if (restart) begin
         per_cnt   <= '0;
         tick_seen <= 1'b0;
      end else begin
         if (per_cnt != CAP_V) per_cnt <= per_cnt + 1'b1;
         if (osc_tick)         tick_seen <= 1'b1;
      end
   end

   assign period_ok = (per_cnt >= FLOOR_V) && (tick_seen || osc_tick || per_cnt == CAP_V);

   // R1: a restart never arrives before the minimum period has run
   p_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (per_cnt >= FLOOR_V));
endmodule

// File: rtl/qr_cycle_seq.sv
module qr_cycle_seq
   import qr_seq_pkg::*;
#(
   parameter int unsigned BLANK_CYC      = 46,
   parameter int unsigned MAXON_CYC      = 6250,
   parameter int unsigned RING_CYC       = 188,
   parameter int unsigned MIN_PERIOD_CYC = 1000,
   parameter int unsigned MAX_PERIOD_CYC = 5000,
   parameter int unsigned VALLEY_TO_CYC  = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic demag_active,
   input  logic valley_det,
   input  logic cs_trip,
   input  logic sw_trip,
   input  logic skip_req,
   output logic gate_on,
   output logic fault_maxon,
   output logic fault_short
);
   localparam int unsigned PH_LIMIT = qr_max3(MAXON_CYC, RING_CYC, VALLEY_TO_CYC);
   localparam int unsigned PH_W     = $clog2(PH_LIMIT + 1);
   localparam int unsigned PER_W    = $clog2(MAX_PERIOD_CYC + 1);

   initial begin : g_chk
      assert (BLANK_CYC >= 1)               else $error("blanking must be at least one cycle");
      assert (MAXON_CYC > BLANK_CYC)        else $error("on-time ceiling must exceed blanking");
      assert (RING_CYC >= 1)                else $error("ringing window must be at least one cycle");
      assert (MIN_PERIOD_CYC >= 1)          else $error("minimum period must be positive");
      assert (MAX_PERIOD_CYC > MIN_PERIOD_CYC) else $error("period cap must exceed floor");
   end

   qr_state_t       st_q, st_d;
   logic [PH_W-1:0] ph_cnt;
   logic            ph_clr, restart, set_maxon, set_short;
   logic            period_ok, blank_done, vto_hit;

   qr_phase_timer #(.W(PH_W), .LIMIT(PH_LIMIT)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(ph_clr), .cnt(ph_cnt)
   );

   qr_period_gate #(.MIN_PERIOD_CYC(MIN_PERIOD_CYC), .MAX_PERIOD_CYC(MAX_PERIOD_CYC),
                    .W(PER_W)) u_period (
      .clk(clk), .rst_n(rst_n), .restart(restart), .osc_tick(osc_tick),
      .period_ok(period_ok)
   );

   assign blank_done = (ph_cnt >= PH_W'(BLANK_CYC - 1));

   generate
      if (VALLEY_TO_CYC == 0) begin : g_no_vto
         assign vto_hit = 1'b0;
      end else begin : g_vto
         assign vto_hit = (ph_cnt >= PH_W'(VALLEY_TO_CYC - 1));
      end
   endgenerate

   always_comb begin
      st_d      = st_q;
      ph_clr    = 1'b0;
      restart   = 1'b0;
      set_maxon = 1'b0;
      set_short = 1'b0;
      unique case (st_q)
         ST_ON: begin
            if (blank_done && sw_trip) begin
               st_d      = ST_FAULT;
               set_short = 1'b1;
            end else if (blank_done && cs_trip) begin
               st_d   = ST_RING;
               ph_clr = 1'b1;
            end else if (ph_cnt == PH_W'(MAXON_CYC - 1)) begin
               st_d      = ST_FAULT;
               set_maxon = 1'b1;
            end
         end
         ST_RING: begin
            if (ph_cnt == PH_W'(RING_CYC - 1)) begin
               st_d   = ST_DEMAG;
               ph_clr = 1'b1;
            end
         end
         ST_DEMAG: begin
            if (!demag_active) begin
               st_d   = ST_VALLEY;
               ph_clr = 1'b1;
            end
         end
         ST_VALLEY: begin
            if (demag_active) begin
               st_d = ST_DEMAG;
            end else if (period_ok && !skip_req && (valley_det || vto_hit)) begin
               st_d    = ST_ON;
               ph_clr  = 1'b1;
               restart = 1'b1;
            end
         end
         default: st_d = ST_FAULT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_DEMAG;
         gate_on     <= 1'b0;
         fault_maxon <= 1'b0;
         fault_short <= 1'b0;
      end else begin
         st_q    <= st_d;
         gate_on <= (st_d == ST_ON);
         if (set_maxon) fault_maxon <= 1'b1;
         if (set_short) fault_short <= 1'b1;
      end
   end

   // R1: switch-on only through an open period gate
   p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on) |-> $past(period_ok));
   // R2: no switch-on while demagnetization is in progress
   p_demag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on) |-> !$past(demag_active));
   // R3: gate held during blanking
   p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on && ph_cnt < PH_W'(BLANK_CYC - 1)) |=> gate_on);
   // R4: on-time never passes its ceiling
   p_maxon_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gate_on |-> (ph_cnt <= PH_W'(MAXON_CYC - 1)));
   // R6: switch-on needs a valley or an expired valley wait
   p_valley_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on) |-> ($past(valley_det) || $past(vto_hit)));
   // R7: a switch-off is never followed at once by a new switch-on
   p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_on) |=> !gate_on);
   // R8: no switch-on under a skip request
   p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on) |-> !$past(skip_req));
   // R9: short-winding flag only follows a short-winding trip
   p_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_short) |-> ($past(sw_trip) && !gate_on));
   // R10: faults are sticky and keep the gate low
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_maxon || fault_short) |=>
         ($stable(fault_maxon) && $stable(fault_short) && !gate_on));
endmodule

// File: tb/qr_cycle_seq_bench.sv
module qr_cycle_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_tick = 1'b0, demag_active = 1'b0, valley_det = 1'b0;
   logic cs_trip = 1'b0, sw_trip = 1'b0, skip_req = 1'b1;
   logic gate_on, fault_maxon, fault_short;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      int    width;
      int    gap;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   qr_cycle_seq #(
      .BLANK_CYC(4), .MAXON_CYC(40), .RING_CYC(3),
      .MIN_PERIOD_CYC(12), .MAX_PERIOD_CYC(60), .VALLEY_TO_CYC(20)
   ) u_qr_cycle_seq (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .demag_active(demag_active),
      .valley_det(valley_det), .cs_trip(cs_trip), .sw_trip(sw_trip), .skip_req(skip_req),
      .gate_on(gate_on), .fault_maxon(fault_maxon), .fault_short(fault_short)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // monitor: measure every gate pulse and compare with the scoreboard
   int  hi_n = 0, lo_n = 0, cur_gap = -1;
   bit  prev_g = 1'b0, have_fall = 1'b0;
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_g = 1'b0; have_fall = 1'b0; hi_n = 0; lo_n = 0;
      end else begin
         if (gate_on && !prev_g) begin
            cur_gap = have_fall ? lo_n : -1;
            hi_n = 1;
         end else if (gate_on) begin
            hi_n++;
         end else if (prev_g) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "scoreboard-empty", hi_n, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(hi_n == e.width, {e.tag, " width"}, hi_n, e.width);
               if (e.gap >= 0) chk(cur_gap == e.gap, {e.tag, " gap"}, cur_gap, e.gap);
            end
            have_fall = 1'b1;
            lo_n = 1;
         end else begin
            lo_n++;
         end
         prev_g = gate_on;
      end
   end

   // driver: set the off-time conditions for the next pulse, push its expectation,
   // then shape the on-time.  cs_mode: 0 held high, >0 trip after that many cycles, <0 never
   task automatic run_pulse(input int w, input int g, input string tag, input bit tk,
                            input bit vl, input int dmode, input int cs_mode,
                            input bit sw_blank, input bit sw_hold, input int skip_n);
      osc_tick   = tk;
      valley_det = vl;
      cs_trip    = (cs_mode == 0);
      sw_trip    = sw_hold;
      sb_q.push_back('{w, g, tag});
      if (skip_n > 0) begin
         skip_req = 1'b1;
         repeat (skip_n) @(negedge clk);
         skip_req = 1'b0;
      end
      if (dmode == 1) begin
         demag_active = 1'b1;
         repeat (15) @(negedge clk);
         demag_active = 1'b0;
      end else if (dmode == 2) begin
         demag_active = 1'b0;
         repeat (2) @(negedge clk);
         demag_active = 1'b1;
         repeat (13) @(negedge clk);
         demag_active = 1'b0;
      end
      while (gate_on !== 1'b1) @(negedge clk);
      osc_tick = 1'b0;
      if (sw_blank) begin
         sw_trip = 1'b1;
         repeat (3) @(negedge clk);
         sw_trip = 1'b0;
      end
      if (cs_mode > 0) begin
         repeat (cs_mode - 1) @(negedge clk);
         cs_trip = 1'b1;
      end
      while (gate_on === 1'b1) @(negedge clk);
      cs_trip = 1'b0;
      sw_trip = 1'b0;
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", checks, fails);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=timeout exp=finish");
         summary();
         $finish;
      end
   end

   initial begin : main
      int highs;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(gate_on == 1'b0, "R11 gate", gate_on, 0);
      chk(fault_maxon == 1'b0, "R11 fault_maxon", fault_maxon, 0);
      chk(fault_short == 1'b0, "R11 fault_short", fault_short, 0);
      // R8: skip request holds the switch off
      osc_tick = 1'b1; valley_det = 1'b1;
      highs = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (gate_on) highs++;
      end
      chk(highs == 0, "R8 inhibit", highs, 0);
      skip_req = 1'b0;

      // R3: blanking hides a short-winding trip and sets the on-time
      run_pulse(4, -1, "R3", 1, 1, 0, 0, 1, 0, 0);
      chk(fault_short == 1'b0, "R3 blanked sw_trip", fault_short, 0);
      run_pulse(4, 8,  "R1 min period", 1, 1, 0, 0, 0, 0, 0);
      run_pulse(4, 31, "R8 release",    1, 1, 0, 0, 0, 0, 30);
      run_pulse(4, 24, "R6 valley timeout", 1, 0, 0, 0, 0, 0, 0);
      run_pulse(4, 56, "R1 period cap", 0, 0, 0, 0, 0, 0, 0);
      run_pulse(4, 17, "R2 late demag end", 1, 1, 1, 0, 0, 0, 0);
      run_pulse(4, 17, "R5 ringing ignored", 1, 1, 2, 0, 0, 0, 0);
      run_pulse(7, 8,  "R7 late trip", 1, 1, 0, 7, 0, 0, 0);
      run_pulse(4, 5,  "R7 single on", 1, 1, 0, 0, 0, 0, 0);
      // R9: short-winding trip with sense trip in the same cycle
      run_pulse(4, 8,  "R9 short trip", 1, 1, 0, 0, 0, 1, 0);
      chk(fault_short == 1'b1, "R9 fault_short", fault_short, 1);
      chk(fault_maxon == 1'b0, "R9 fault_maxon", fault_maxon, 0);
      // R10: fault is sticky
      osc_tick = 1'b1; valley_det = 1'b1;
      highs = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (gate_on) highs++;
      end
      chk(highs == 0, "R10 gate held low", highs, 0);
      chk(fault_short == 1'b1, "R10 flag held", fault_short, 1);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fault_short == 1'b0, "R10 reset clears", fault_short, 0);

      // R4: on-time ceiling
      run_pulse(40, -1, "R4 ceiling", 1, 1, 0, -1, 0, 0, 0);
      chk(fault_maxon == 1'b1, "R4 fault_maxon", fault_maxon, 1);
      highs = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (gate_on) highs++;
      end
      chk(highs == 0, "R4 stopped", highs, 0);
      chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule